// File: doc/BRIEF.md
# Serial Flash Program/Erase Sequencer

This block sits between a block-storage client and a serial flash frame engine. The client asks for one of three jobs: a quad read, a sector erase, or a write of a byte range. The block turns each job into a sequence of flash commands. It hands the commands to the frame engine one at a time and pulses `done` once the last command has finished. The write data itself travels from the client to the frame engine directly. The sequencer only decides where each program command starts and how many bytes it carries.

A write is cut into program chunks so that no chunk runs past the end of a 256-byte page. Before every chunk and before every erase, the sequencer does two things. First it reads the status register until the device reports it is neither busy nor write-enabled. Then it sends a write-enable command. A whole-block write erases its sector first and then programs from the start of that sector. A partial write goes to the sector base plus a byte offset and has no erase. The busy poll has an iteration cap. Running into the cap aborts the job with an error flag.

Top module: `flash_seq`

## Requirements
- R1: After reset, `reqReady` is 1 and `cmdValid`, `done` and `errFlag` are 0.
- R2: Each program chunk has length min(bytes remaining, 256 − (chunk address mod 256)), so no chunk crosses a 256-byte page boundary.
- R3: A readiness poll is opcode 0x05 with no address, no dummy cycles, single-line, read direction (`cmdWrite`=0) and length 1. The poll is repeated until `cmdStatus` bits 1:0, sampled with `cmdDone`, are both 0.
- R4: A write enable (opcode 0x06, no address, `cmdWrite`=1, length 0) immediately follows each successful poll that precedes a program or an erase. Every program and every erase is immediately preceded by one.
- R5: A program command is opcode 0x32 with the chunk address, address enabled, no dummy cycles, quad data (`cmdQuad`=1), write direction and the chunk length.
- R6: An erase request (`reqKind`=2) issues poll, write enable, then opcode 0x20 at address `reqBlock`×4096. The erase command has the address enabled, no data (length 0), write direction and single-line transfer.
- R7: A read request (`reqKind`=0) polls, then issues opcode 0x6B at `reqBlock`×4096+`reqOffset`. The read has the address enabled, 8 dummy cycles, quad data, read direction and length `reqLen`. A read of length 0 issues no command.
- R8: A write request (`reqKind`=1) with `reqWhole`=1 first erases the sector at `reqBlock`×4096 and then programs from that address. With `reqWhole`=0 it programs from `reqBlock`×4096+`reqOffset` and issues no erase.
- R9: After each chunk, the address and the position both advance by the chunk length. The job ends when the position equals the length. `done` is then a one-cycle pulse, after which `reqReady` is 1. A partial write of length 0 issues no command.
- R10: If `POLL_LIMIT` consecutive polls all report not-ready, no further command is issued. `errFlag` is set in the same cycle as the `done` pulse, and the block returns to idle. `errFlag` is cleared when the next request is accepted.
- R11: `reqValid` is ignored while `reqReady` is 0. A request presented during a job changes neither the current sequence nor the commands that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is 1 |
| reqKind | input | 2 | 0 read, 1 write, 2 erase |
| reqWhole | input | 1 | Write covers a whole sector (erase first, offset ignored) |
| reqBlock | input | ADDR_W-12 | Sector number |
| reqOffset | input | ADDR_W | Byte offset within the area, for reads and partial writes |
| reqLen | input | LEN_W | Byte length |
| reqReady | output | 1 | Idle and able to take a request |
| cmdValid | output | 1 | A command is presented to the frame engine |
| cmdOpcode | output | 8 | Instruction byte |
| cmdAddr | output | ADDR_W | Command address (0 when unused) |
| cmdAddrEn | output | 1 | Address phase present |
| cmdDummy | output | 4 | Dummy cycle count |
| cmdQuad | output | 1 | Data phase on four lines |
| cmdWrite | output | 1 | Data direction towards the flash |
| cmdLen | output | LEN_W | Data phase length in bytes |
| cmdDone | input | 1 | One-cycle pulse: the presented command has finished |
| cmdStatus | input | 8 | Status byte returned with cmdDone of a poll |
| done | output | 1 | One-cycle pulse at the end of a job |
| errFlag | output | 1 | The last job was aborted by the poll limit |

## Verification
The next command appears in the first cycle after the cycle in which `cmdDone` is sampled. The bench's engine model therefore compares each new command at the falling edge that follows the edge which consumed `cmdDone`. `done` rises one cycle after the final `cmdDone`. For an empty request, `done` rises in the cycle right after acceptance. The bench polls for `done` only at falling edges and checks that it has dropped one cycle later. `errFlag` is compared at the same falling edge as `done`, and again at the falling edge after the next request is accepted.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h32;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_QREAD  = 8'h6B;

  localparam logic [1:0] REQ_READ  = 2'd0;
  localparam logic [1:0] REQ_WRITE = 2'd1;
  localparam logic [1:0] REQ_ERASE = 2'd2;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_POLL, CMD_WREN, CMD_ERASE, CMD_PROG, CMD_READ
  } cmdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    advance;
    logic    pollInc;
    logic    pollClr;
    cmdSel_e sel;
  } seqStrobe_t;
endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int SECTOR_LG  = 12,
  parameter int POLL_LIMIT = 16,
  parameter int READ_DUMMY = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              strobe,
  input  logic [1:0]              reqKind,
  input  logic                    reqWhole,
  input  logic [ADDR_W-SECTOR_LG-1:0] reqBlock,
  input  logic [ADDR_W-1:0]       reqOffset,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic [7:0]              cmdStatus,
  output logic                    reqEmpty,
  output logic                    statusReady,
  output logic                    pollExpired,
  output logic                    lastChunk,
  output logic                    posDone,
  output logic                    cmdValid,
  output logic [7:0]              cmdOpcode,
  output logic [ADDR_W-1:0]       cmdAddr,
  output logic                    cmdAddrEn,
  output logic [3:0]              cmdDummy,
  output logic                    cmdQuad,
  output logic                    cmdWrite,
  output logic [LEN_W-1:0]        cmdLen
);
  localparam int PAGE_LG = $clog2(PAGE_BYTES);
  localparam int PC_W    = $clog2(POLL_LIMIT + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  total, pos;
  logic [PC_W-1:0]   pollCnt;
  logic [LEN_W-1:0]  room, remain, chunk;
  logic [ADDR_W-1:0] baseAddr;
  logic              useOffset;

  assign baseAddr  = {reqBlock, {SECTOR_LG{1'b0}}};
  assign useOffset = (reqKind == REQ_READ) || (reqKind == REQ_WRITE && !reqWhole);
  assign room      = LEN_W'(PAGE_BYTES) - LEN_W'(curAddr[PAGE_LG-1:0]);
  assign remain    = total - pos;
  assign chunk     = (remain < room) ? remain : room;

  assign reqEmpty    = (reqLen == '0);
  assign statusReady = (cmdStatus[1:0] == 2'b00);
  assign pollExpired = (pollCnt == PC_W'(POLL_LIMIT - 1));
  assign lastChunk   = (remain <= room);
  assign posDone     = (pos == total);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      total   <= '0;
      pos     <= '0;
      pollCnt <= '0;
    end else begin
      if (strobe.load) begin
        curAddr <= baseAddr + (useOffset ? reqOffset : '0);
        total   <= reqLen;
        pos     <= '0;
      end else if (strobe.advance) begin
        curAddr <= curAddr + ADDR_W'(chunk);
        pos     <= pos + chunk;
      end
      if (strobe.pollClr)      pollCnt <= '0;
      else if (strobe.pollInc) pollCnt <= pollCnt + 1'b1;
    end
  end

  always_comb begin
    cmdValid  = 1'b1;
    cmdOpcode = 8'h00;
    cmdAddr   = '0;
    cmdAddrEn = 1'b0;
    cmdDummy  = 4'd0;
    cmdQuad   = 1'b0;
    cmdWrite  = 1'b0;
    cmdLen    = '0;
    case (strobe.sel)
      CMD_POLL: begin
        cmdOpcode = OP_STATUS;
        cmdLen    = LEN_W'(1);
      end
      CMD_WREN: begin
        cmdOpcode = OP_WREN;
        cmdWrite  = 1'b1;
      end
      CMD_ERASE: begin
        cmdOpcode = OP_ERASE;
        cmdAddr   = curAddr;
        cmdAddrEn = 1'b1;
        cmdWrite  = 1'b1;
      end
      CMD_PROG: begin
        cmdOpcode = OP_PROG;
        cmdAddr   = curAddr;
        cmdAddrEn = 1'b1;
        cmdQuad   = 1'b1;
        cmdWrite  = 1'b1;
        cmdLen    = chunk;
      end
      CMD_READ: begin
        cmdOpcode = OP_QREAD;
        cmdAddr   = curAddr;
        cmdAddrEn = 1'b1;
        cmdDummy  = 4'(READ_DUMMY);
        cmdQuad   = 1'b1;
        cmdLen    = total;
      end
      default: cmdValid = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqWhole,
  input  logic       reqEmpty,
  input  logic       cmdDone,
  input  logic       statusReady,
  input  logic       pollExpired,
  input  logic       lastChunk,
  input  logic       posDone,
  output seqStrobe_t strobe,
  output logic       reqReady,
  output logic       done,
  output logic       errFlag
);
  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_WREN, S_ERASE, S_PROG, S_READ, S_FIN
  } state_e;

  state_e     state, nxtState;
  logic [1:0] kind, nxtKind;
  logic       erasePend, nxtErasePend, nxtErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      kind      <= REQ_READ;
      erasePend <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      state     <= nxtState;
      kind      <= nxtKind;
      erasePend <= nxtErasePend;
      errFlag   <= nxtErr;
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.sel   = CMD_NONE;
    nxtState     = state;
    nxtKind      = kind;
    nxtErasePend = erasePend;
    nxtErr       = errFlag;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.load    = 1'b1;
        strobe.pollClr = 1'b1;
        nxtErr         = 1'b0;
        nxtKind        = reqKind;
        nxtErasePend   = (reqKind == REQ_ERASE) || (reqKind == REQ_WRITE && reqWhole);
        if (reqKind == REQ_ERASE)                           nxtState = S_POLL;
        else if (reqKind == REQ_WRITE && reqWhole)          nxtState = S_POLL;
        else if (reqKind == REQ_READ || reqKind == REQ_WRITE)
          nxtState = reqEmpty ? S_FIN : S_POLL;
        else                                                nxtState = S_FIN;
      end
      S_POLL: begin
        strobe.sel = CMD_POLL;
        if (cmdDone) begin
          if (statusReady) begin
            strobe.pollClr = 1'b1;
            nxtState = (kind == REQ_READ) ? S_READ : S_WREN;
          end else if (pollExpired) begin
            nxtErr   = 1'b1;
            nxtState = S_FIN;
          end else begin
            strobe.pollInc = 1'b1;
          end
        end
      end
      S_WREN: begin
        strobe.sel = CMD_WREN;
        if (cmdDone) nxtState = erasePend ? S_ERASE : S_PROG;
      end
      S_ERASE: begin
        strobe.sel = CMD_ERASE;
        if (cmdDone) begin
          nxtErasePend = 1'b0;
          nxtState = (kind == REQ_WRITE && !posDone) ? S_POLL : S_FIN;
        end
      end
      S_PROG: begin
        strobe.sel = CMD_PROG;
        if (cmdDone) begin
          strobe.advance = 1'b1;
          nxtState = lastChunk ? S_FIN : S_POLL;
        end
      end
      S_READ: begin
        strobe.sel = CMD_READ;
        if (cmdDone) nxtState = S_FIN;
      end
      default: nxtState = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign done     = (state == S_FIN);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int SECTOR_LG  = 12,
  parameter int POLL_LIMIT = 16,
  parameter int READ_DUMMY = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [1:0]                  reqKind,
  input  logic                        reqWhole,
  input  logic [ADDR_W-SECTOR_LG-1:0] reqBlock,
  input  logic [ADDR_W-1:0]           reqOffset,
  input  logic [LEN_W-1:0]            reqLen,
  output logic                        reqReady,
  output logic                        cmdValid,
  output logic [7:0]                  cmdOpcode,
  output logic [ADDR_W-1:0]           cmdAddr,
  output logic                        cmdAddrEn,
  output logic [3:0]                  cmdDummy,
  output logic                        cmdQuad,
  output logic                        cmdWrite,
  output logic [LEN_W-1:0]            cmdLen,
  input  logic                        cmdDone,
  input  logic [7:0]                  cmdStatus,
  output logic                        done,
  output logic                        errFlag
);
  seqStrobe_t strobe;
  logic reqEmpty, statusReady, pollExpired, lastChunk, posDone;

  flash_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqWhole(reqWhole), .reqEmpty(reqEmpty), .cmdDone(cmdDone),
    .statusReady(statusReady), .pollExpired(pollExpired),
    .lastChunk(lastChunk), .posDone(posDone), .strobe(strobe),
    .reqReady(reqReady), .done(done), .errFlag(errFlag)
  );

  flash_seq_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
    .SECTOR_LG(SECTOR_LG), .POLL_LIMIT(POLL_LIMIT), .READ_DUMMY(READ_DUMMY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqKind(reqKind),
    .reqWhole(reqWhole), .reqBlock(reqBlock), .reqOffset(reqOffset),
    .reqLen(reqLen), .cmdStatus(cmdStatus), .reqEmpty(reqEmpty),
    .statusReady(statusReady), .pollExpired(pollExpired),
    .lastChunk(lastChunk), .posDone(posDone), .cmdValid(cmdValid),
    .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr), .cmdAddrEn(cmdAddrEn),
    .cmdDummy(cmdDummy), .cmdQuad(cmdQuad), .cmdWrite(cmdWrite),
    .cmdLen(cmdLen)
  );
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              cmdValid,
  input logic [7:0]        cmdOpcode,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [LEN_W-1:0]  cmdLen,
  input logic              cmdDone,
  input logic              done,
  input logic              errFlag
);
  localparam int PAGE_LG = $clog2(PAGE_BYTES);

  logic [7:0] prevDoneOp;
  always_ff @(posedge clk) begin
    if (!rstN) prevDoneOp <= 8'h00;
    else if (cmdDone && cmdValid) prevDoneOp <= cmdOpcode;
  end

  a_r2_page_bound: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == OP_PROG) |->
      (cmdLen != '0 && (int'(cmdAddr[PAGE_LG-1:0]) + int'(cmdLen)) <= PAGE_BYTES));

  a_r4_wren_before_prog: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == OP_PROG) |-> prevDoneOp == OP_WREN);

  a_r4_wren_before_erase: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == OP_ERASE) |-> prevDoneOp == OP_WREN);

  a_r4_poll_before_wren: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == OP_WREN) |-> prevDoneOp == OP_STATUS);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !cmdValid);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> done);
endmodule

bind flash_seq flash_seq_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .cmdValid(cmdValid),
  .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
  .cmdDone(cmdDone), .done(done), .errFlag(errFlag)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic        reqWhole = 1'b0;
  logic [11:0] reqBlock = '0;
  logic [23:0] reqOffset = '0;
  logic [15:0] reqLen = '0;
  logic        reqReady, cmdValid, cmdAddrEn, cmdQuad, cmdWrite, done, errFlag;
  logic [7:0]  cmdOpcode;
  logic [23:0] cmdAddr;
  logic [3:0]  cmdDummy;
  logic [15:0] cmdLen;
  logic        cmdDone = 1'b0;
  logic [7:0]  cmdStatus = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq #(.POLL_LIMIT(LIMIT)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqWhole(reqWhole), .reqBlock(reqBlock), .reqOffset(reqOffset),
    .reqLen(reqLen), .reqReady(reqReady), .cmdValid(cmdValid),
    .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr), .cmdAddrEn(cmdAddrEn),
    .cmdDummy(cmdDummy), .cmdQuad(cmdQuad), .cmdWrite(cmdWrite),
    .cmdLen(cmdLen), .cmdDone(cmdDone), .cmdStatus(cmdStatus),
    .done(done), .errFlag(errFlag)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic        ae;
    logic [3:0]  dm;
    logic        q;
    logic        w;
    logic [15:0] len;
  } expCmd_t;

  expCmd_t    expQ[$];
  logic [7:0] statusQ[$];
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  function automatic string tagOf(logic [7:0] op);
    case (op)
      8'h05: return "R3";
      8'h06: return "R4";
      8'h32: return "R5/R2";
      8'h20: return "R6";
      8'h6B: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pushCmd(logic [7:0] op, logic [23:0] a, logic ae, logic [3:0] dm,
                         logic q, logic w, logic [15:0] l);
    expCmd_t e;
    e.op = op; e.addr = a; e.ae = ae; e.dm = dm; e.q = q; e.w = w; e.len = l;
    expQ.push_back(e);
  endtask

  task automatic pushPoll();  pushCmd(8'h05, 24'h0, 1'b0, 4'd0, 1'b0, 1'b0, 16'd1); endtask
  task automatic pushWren();  pushCmd(8'h06, 24'h0, 1'b0, 4'd0, 1'b0, 1'b1, 16'd0); endtask

  // frame engine model and scoreboard monitor
  initial begin
    bit inFrame = 0;
    int waitCnt = 0;
    logic [7:0] curOp = 8'h00;
    forever begin
      @(negedge clk);
      cmdDone = 1'b0;
      if (!inFrame && cmdValid && rstN) begin
        expCmd_t act, exp;
        act = {cmdOpcode, cmdAddr, cmdAddrEn, cmdDummy, cmdQuad, cmdWrite, cmdLen};
        curOp = cmdOpcode;
        if (expQ.size() == 0) begin
          check(1'b0, tagOf(cmdOpcode), "unexpected command", act, 0);
        end else begin
          exp = expQ.pop_front();
          check(act == exp, tagOf(exp.op), "command fields", act, exp);
        end
        inFrame = 1;
        waitCnt = 2;
      end else if (inFrame) begin
        if (waitCnt == 0) begin
          cmdDone = 1'b1;
          if (curOp == 8'h05 && statusQ.size() > 0) cmdStatus = statusQ.pop_front();
          else cmdStatus = 8'h00;
          inFrame = 0;
        end else waitCnt--;
      end
    end
  end

  // kind: 0 read, 1 write, 2 erase
  task automatic doReq(logic [1:0] kind, logic whole, logic [11:0] blk, logic [23:0] off,
                       logic [15:0] len, int extra, bit expErr, bit poke, string tag);
    logic [23:0] base, a;
    int pos, c, n;
    base = {blk, 12'h000};
    a = (kind == 2'd0 || (kind == 2'd1 && !whole)) ? base + off : base;
    if (expErr) begin
      for (int i = 0; i < LIMIT; i++) begin pushPoll(); statusQ.push_back(8'h01); end
    end else begin
      for (int i = 0; i < extra; i++) begin
        pushPoll(); statusQ.push_back((i % 2 == 0) ? 8'h02 : 8'h01);
      end
      if (kind == 2'd0) begin
        if (len != 0) begin
          pushPoll();
          pushCmd(8'h6B, a, 1'b1, 4'd8, 1'b1, 1'b0, len);
        end
      end else begin
        if (kind == 2'd2 || whole) begin
          pushPoll(); pushWren();
          pushCmd(8'h20, base, 1'b1, 4'd0, 1'b0, 1'b1, 16'd0);
        end
        if (kind == 2'd1) begin
          pos = 0;
          while (pos < int'(len)) begin
            c = 256 - int'(a[7:0]);
            if (int'(len) - pos < c) c = int'(len) - pos;
            pushPoll(); pushWren();
            pushCmd(8'h32, a, 1'b1, 4'd0, 1'b1, 1'b1, 16'(c));
            a = a + 24'(c);
            pos += c;
          end
        end
      end
    end
    @(negedge clk);
    check(reqReady == 1'b1, tag, "ready before request", reqReady, 1);
    reqValid = 1'b1; reqKind = kind; reqWhole = whole;
    reqBlock = blk; reqOffset = off; reqLen = len;
    @(negedge clk);
    reqValid = 1'b0;
    check(errFlag == 1'b0, "R10", "error cleared on accept", errFlag, 0);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 20) begin
        reqValid = 1'b1; reqKind = 2'd0; reqOffset = 24'h55; reqLen = 16'd7;
      end
      if (poke && n == 21) reqValid = 1'b0;
    end
    check(done == 1'b1, "R9", "done pulse seen", done, 1);
    check(errFlag == expErr, expErr ? "R10" : tag, "error flag at done", errFlag, expErr);
    check(expQ.size() == 0, tag, "all expected commands issued", expQ.size(), 0);
    @(negedge clk);
    check(done == 1'b0 && reqReady == 1'b1, "R9", "done one cycle then idle",
          {done, reqReady}, 2'b01);
    expQ.delete();
    statusQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "reset reqReady", reqReady, 1);
    check(cmdValid == 1'b0, "R1", "reset cmdValid", cmdValid, 0);
    check(done == 1'b0 && errFlag == 1'b0, "R1", "reset done/errFlag", {done, errFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && cmdValid == 1'b0, "R1", "idle after reset",
          {reqReady, cmdValid}, 2'b10);

    doReq(2'd0, 1'b0, 12'h001, 24'h010, 16'd64, 0, 0, 0, "R7");      // quad read
    doReq(2'd0, 1'b0, 12'h001, 24'h010, 16'd0, 0, 0, 0, "R7");       // empty read
    doReq(2'd2, 1'b0, 12'h002, 24'h123, 16'd0, 0, 0, 0, "R6");       // erase ignores offset
    doReq(2'd1, 1'b0, 12'h000, 24'h0F0, 16'h120, 0, 0, 0, "R2");     // 16+256+16 chunks
    doReq(2'd1, 1'b1, 12'h003, 24'h0AA, 16'd300, 0, 0, 0, "R8");     // erase then 256+44
    doReq(2'd1, 1'b0, 12'h004, 24'h0FF, 16'd2, 2, 0, 0, "R3");       // busy polls, 1+1
    doReq(2'd0, 1'b0, 12'h005, 24'h000, 16'd8, 0, 1, 0, "R10");      // poll limit hit
    doReq(2'd1, 1'b0, 12'h006, 24'h040, 16'd512, 0, 0, 1, "R11");    // poke while busy
    doReq(2'd1, 1'b0, 12'h007, 24'h000, 16'd0, 0, 0, 0, "R9");       // empty partial write

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule